// File: doc/BRIEF.md
# SPI Service-Request Steering and Control Register

This block is the register and request logic that sits beside an SPI shift engine. It holds a small control register that sets whether the port acts as bus master or slave, the serial clock's idle level and its sampling phase, and two per-event enables. It also holds one bit that chooses who services the port. The shift engine drives two status levels into the block: the receive buffer is full, and the transmit buffer is empty. For each status level the block raises exactly one kind of request. It raises either a CPU interrupt line or a DMA service request line, as the service-select bit directs. It never raises both.

The block also checks one framing rule. In slave operation with clock phase 0, the slave-select line must go high between bytes. When a byte begins and the select line has not gone high since the previous byte began, the block sets a sticky fault flag. Software clears the flag by writing a 1 to it. All fields are reached through a simple synchronous port. A write lands on the clock edge, and a read returns the current values combinationally.

Top module: `spi_svc_ctrl`

## Requirements
- R1: After reset the control register (address 0) reads 0x28: master bit (bit 3) and phase bit (bit 5) set, and polarity (bit 4), service select (bit 2), transmit enable (bit 1) and receive enable (bit 0) clear. The fault flag reads 0.
- R2: A write to address 0 updates the control fields at that clock edge. Reads return them, and `master_mode`, `clk_pol` and `clk_pha` follow bits 3, 4 and 5 from the next cycle on.
- R3: With service select 0, `irq_rx` equals receive-full AND receive enable, and `irq_tx` equals transmit-empty AND transmit enable. Both DMA requests stay low.
- R4: With service select 1, `dma_rx_req` equals receive-full AND receive enable, and `dma_tx_req` equals transmit-empty AND transmit enable. Both interrupt lines stay low.
- R5: For either event, the interrupt line and the DMA line are never high in the same cycle.
- R6: A write that changes service select moves a pending request to the other path in the cycle after the write edge. The request is not duplicated.
- R7: In slave mode with phase 0, a byte start (`xfer_start` high) sets the fault flag one edge later if `slave_sel_n` has not been high since the previous byte start. The first byte after reset counts as armed.
- R8: A byte start does not set the fault flag in master mode, with phase 1, or after `slave_sel_n` has been high since the previous byte start.
- R9: Writing address 1 with bit 0 set clears the fault flag. Writing it with bit 0 clear leaves the flag unchanged. A fault set in the same cycle as a clear wins.
- R10: Address 1 reads fault in bit 0, receive-full in bit 1 and transmit-empty in bit 2, with the upper bits 0.
- R11: Bits 7:6 of address 0 ignore writes and read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| rx_full | input | 1 | Receive buffer full, from shift engine |
| tx_empty | input | 1 | Transmit buffer empty, from shift engine |
| xfer_start | input | 1 | One-cycle pulse when a byte begins |
| slave_sel_n | input | 1 | Slave-select line, active low |
| irq_rx | output | 1 | CPU interrupt for receive-full |
| irq_tx | output | 1 | CPU interrupt for transmit-empty |
| dma_rx_req | output | 1 | DMA request for receive-full |
| dma_tx_req | output | 1 | DMA request for transmit-empty |
| master_mode | output | 1 | 1 = master, 0 = slave |
| clk_pol | output | 1 | Serial clock idle level |
| clk_pha | output | 1 | Serial clock phase |
| mode_fault | output | 1 | Sticky framing fault |

## Verification
The four request lines depend combinationally on the status inputs, so they follow a status change in the same cycle. A control write reaches them after a single clock edge. The fault flag and the mode outputs are registered, so they change one edge after the byte start or the write that causes them. The bench drives every input on the falling edge and samples on the following falling edge. A registered result has then passed exactly one rising edge, and a combinational one has settled within the same half period.

// File: rtl/spi_svc_pkg.sv
// Package: shared constants and types for the SPI service-request block.
// Assumes an 8-bit data path; the bit positions below are the register layout.
package spi_svc_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 2'd1;

    localparam int B_RXIE = 0;
    localparam int B_TXIE = 1;
    localparam int B_DSEL = 2;
    localparam int B_MSTR = 3;
    localparam int B_CPOL = 4;
    localparam int B_CPHA = 5;

    localparam int B_FAULT = 0;
    localparam int B_RXF   = 1;
    localparam int B_TXE   = 2;

    localparam logic [DATA_W-1:0] CTRL_RESET = 8'h28;
    localparam logic [DATA_W-1:0] CTRL_MASK  = 8'h3F;
    localparam logic [DATA_W-1:0] W1C_MASK   = 8'h01;

    localparam int NUM_EV = 2;   // event 0 = receive full, event 1 = transmit empty

    typedef struct packed {
        logic cpha;
        logic cpol;
        logic master;
        logic dsel;
        logic tx_ie;
        logic rx_ie;
    } ctrl_t;
endpackage

// File: rtl/spi_svc_regs.sv
// Module: control register and read mux.
// Holds the control fields with their mixed reset defaults and decodes the
// write-one-to-clear strobe for the fault flag. Reads are combinational.
module spi_svc_regs
    import spi_svc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              fault,
    input  logic              rx_full,
    input  logic              tx_empty,
    output ctrl_t             ctrl,
    output logic              fault_clr
);
    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] stat_view;

    // Purpose: store the control fields; reserved bits are masked off.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else if (wr && addr == A_CTRL)
            ctrl_q <= wdata & CTRL_MASK;
    end

    // Purpose: unpack the stored bits into named fields.
    always_comb begin
        ctrl.rx_ie  = ctrl_q[B_RXIE];
        ctrl.tx_ie  = ctrl_q[B_TXIE];
        ctrl.dsel   = ctrl_q[B_DSEL];
        ctrl.master = ctrl_q[B_MSTR];
        ctrl.cpol   = ctrl_q[B_CPOL];
        ctrl.cpha   = ctrl_q[B_CPHA];
    end

    // Purpose: assemble the status view.
    always_comb begin
        stat_view          = '0;
        stat_view[B_FAULT] = fault;
        stat_view[B_RXF]   = rx_full;
        stat_view[B_TXE]   = tx_empty;
    end

    // Purpose: read mux by address.
    always_comb begin
        unique case (addr)
            A_CTRL:  rdata = ctrl_q;
            A_STAT:  rdata = stat_view;
            default: rdata = '0;
        endcase
    end

    // Purpose: clear strobe when a 1 is written to the fault bit.
    assign fault_clr = wr && (addr == A_STAT) && |(wdata & W1C_MASK);

    // R1
    reset_dflt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (ctrl.master && ctrl.cpha && !ctrl.cpol && !ctrl.dsel));
    // R2
    ctrl_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == A_CTRL) |=> (ctrl.master == $past(wdata[B_MSTR])
                                    && ctrl.cpha == $past(wdata[B_CPHA])
                                    && ctrl.dsel == $past(wdata[B_DSEL])));
    // R11
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTRL) |-> (rdata[DATA_W-1:6] == '0));
endmodule

// File: rtl/spi_svc_steer.sv
// Module: per-event request steering.
// For each status event it gates the flag with its enable and routes the
// result to either the CPU interrupt line or the DMA line, by one select bit.
// Assumes the flags are levels held by the shift engine until serviced.
module spi_svc_steer
    import spi_svc_pkg::*;
#(
    parameter int N = NUM_EV
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] flag,
    input  logic [N-1:0] enable,
    input  logic         dsel,
    output logic [N-1:0] irq,
    output logic [N-1:0] dma
);
    for (genvar g = 0; g < N; g++) begin : g_ev
        logic pend;

        // Purpose: an event is pending while its flag and enable are both high.
        always_comb pend = flag[g] & enable[g];

        // Purpose: route a pending event to exactly one path.
        always_comb begin
            irq[g] = pend & ~dsel;
            dma[g] = pend &  dsel;
        end

        // R5
        excl_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(irq[g] && dma[g]));
        // R4
        dma_quiet_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
            dsel |-> !irq[g]);
        // R3
        cpu_quiet_dma_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !dsel |-> !dma[g]);
    end
endmodule

// File: rtl/spi_svc_fault.sv
// Module: slave-select framing check.
// Tracks whether slave select has been high since the last byte start; a byte
// start in slave mode with phase 0 and no such rise sets a sticky fault.
// Assumes xfer_start is a one-cycle pulse per byte from the shift engine.
module spi_svc_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_start,
    input  logic slave_sel_n,
    input  logic master,
    input  logic cpha,
    input  logic clr,
    output logic fault
);
    logic armed_q;
    logic rule_on;
    logic violate;

    // Purpose: the rule applies only to slave operation with phase 0.
    always_comb rule_on = !master && !cpha;
    always_comb violate = xfer_start && !armed_q && rule_on;

    // Purpose: remember a high slave select since the previous byte start.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b1;
        else if (xfer_start)
            armed_q <= 1'b0;
        else if (slave_sel_n)
            armed_q <= 1'b1;
    end

    // Purpose: sticky fault, set wins over write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault <= 1'b0;
        else if (violate)
            fault <= 1'b1;
        else if (clr)
            fault <= 1'b0;
    end

    // R7
    fault_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_start && !armed_q && !master && !cpha) |=> fault);
    // R8
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && !(xfer_start && !master && !cpha)) |=> !fault);
    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !clr) |=> fault);
endmodule

// File: rtl/spi_svc_ctrl.sv
// Module: top of the SPI service-request block.
// Joins the control register, the request steering and the framing check,
// and exposes the mode and clock-format fields to the shift engine.
module spi_svc_ctrl
    import spi_svc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              rx_full,
    input  logic              tx_empty,
    input  logic              xfer_start,
    input  logic              slave_sel_n,
    output logic              irq_rx,
    output logic              irq_tx,
    output logic              dma_rx_req,
    output logic              dma_tx_req,
    output logic              master_mode,
    output logic              clk_pol,
    output logic              clk_pha,
    output logic              mode_fault
);
    ctrl_t             ctrl;
    logic              fault_clr;
    logic [NUM_EV-1:0] ev_flag;
    logic [NUM_EV-1:0] ev_en;
    logic [NUM_EV-1:0] ev_irq;
    logic [NUM_EV-1:0] ev_dma;

    spi_svc_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .addr     (bus_addr),
        .wr       (bus_wr),
        .wdata    (bus_wdata),
        .rdata    (bus_rdata),
        .fault    (mode_fault),
        .rx_full  (rx_full),
        .tx_empty (tx_empty),
        .ctrl     (ctrl),
        .fault_clr(fault_clr)
    );

    // Purpose: pack the events in a fixed order (0 receive, 1 transmit).
    always_comb begin
        ev_flag = {tx_empty, rx_full};
        ev_en   = {ctrl.tx_ie, ctrl.rx_ie};
    end

    spi_svc_steer #(.N(NUM_EV)) u_steer (
        .clk   (clk),
        .rst_n (rst_n),
        .flag  (ev_flag),
        .enable(ev_en),
        .dsel  (ctrl.dsel),
        .irq   (ev_irq),
        .dma   (ev_dma)
    );

    spi_svc_fault u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .slave_sel_n(slave_sel_n),
        .master     (ctrl.master),
        .cpha       (ctrl.cpha),
        .clr        (fault_clr),
        .fault      (mode_fault)
    );

    // Purpose: drive the request and mode outputs.
    always_comb begin
        irq_rx      = ev_irq[0];
        irq_tx      = ev_irq[1];
        dma_rx_req  = ev_dma[0];
        dma_tx_req  = ev_dma[1];
        master_mode = ctrl.master;
        clk_pol     = ctrl.cpol;
        clk_pha     = ctrl.cpha;
    end

    // R6
    move_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rx && bus_wr && bus_addr == A_CTRL && bus_wdata[B_DSEL]
         && bus_wdata[B_RXIE] && $stable(rx_full)) |=> (!irq_rx || !rx_full));
endmodule

// File: tb/spi_svc_ctrl_test.sv
module spi_svc_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rx_full = 1'b0, tx_empty = 1'b0, xfer_start = 1'b0, slave_sel_n = 1'b0;
    logic       irq_rx, irq_tx, dma_rx_req, dma_tx_req, master_mode, clk_pol, clk_pha, mode_fault;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    spi_svc_ctrl uut (.*);

    // Vector: [8:4] = {rx_ie, tx_ie, dsel, rx_full, tx_empty};
    //         [3:0] = {irq_rx, irq_tx, dma_rx_req, dma_tx_req}
    localparam int NV = 8;
    localparam logic [8:0] VEC [NV] = '{
        9'b11011_1100,
        9'b11111_0011,
        9'b10011_1000,
        9'b01111_0001,
        9'b11001_0100,
        9'b11110_0010,
        9'b00011_0000,
        9'b00111_0000
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    initial begin
        #100000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, r); check("R1 ctrl", r, 8'h28);
        rd(2'd1, r); check("R1 fault", {7'b0, r[0]}, 8'h00);
        check("R1 mode pins", {5'b0, master_mode, clk_pol, clk_pha}, 8'b101);

        // R3/R4 steering table
        for (int i = 0; i < NV; i++) begin
            logic [8:0] v;
            v = VEC[i];
            wr(2'd0, {2'b00, 1'b1, 1'b0, 1'b1, v[6], v[7], v[8]});
            @(negedge clk);
            rx_full = v[5]; tx_empty = v[4];
            #1 check(v[6] ? "R4 dma path" : "R3 cpu path",
                     {4'b0, irq_rx, irq_tx, dma_rx_req, dma_tx_req}, {4'b0, v[3:0]});
        end

        // R2 fields read back and drive mode pins; R11 reserved bits
        wr(2'd0, 8'hD0);
        rd(2'd0, r); check("R11 reserved/R2 readback", r, 8'h10);
        check("R2 mode pins", {5'b0, master_mode, clk_pol, clk_pha}, 8'b010);

        // R10 status read
        rx_full = 1'b1; tx_empty = 1'b0;
        rd(2'd1, r); check("R10 status", r, 8'h02);

        // R6 pending receive request moves to DMA after the write edge
        wr(2'd0, 8'h29);
        #1 check("R6 before", {6'b0, irq_rx, dma_rx_req}, 8'b10);
        @(negedge clk);
        bus_addr = 2'd0; bus_wdata = 8'h2D; bus_wr = 1'b1;
        #1 check("R6 same cycle", {6'b0, irq_rx, dma_rx_req}, 8'b10);
        @(negedge clk); bus_wr = 1'b0;
        #1 check("R6 after", {6'b0, irq_rx, dma_rx_req}, 8'b01);
        rx_full = 1'b0;

        // R7 slave, phase 0: first byte armed, second without select high faults
        wr(2'd0, 8'h00);
        slave_sel_n = 1'b0;
        pulse_start();
        #1 check("R7 first byte armed", {7'b0, mode_fault}, 8'h00);
        pulse_start();
        #1 check("R7 fault set", {7'b0, mode_fault}, 8'h01);
        rd(2'd1, r); check("R7 status bit", {7'b0, r[0]}, 8'h01);

        // R9 write 0 keeps, write 1 clears
        wr(2'd1, 8'h00);
        #1 check("R9 write0 keeps", {7'b0, mode_fault}, 8'h01);
        wr(2'd1, 8'h01);
        #1 check("R9 write1 clears", {7'b0, mode_fault}, 8'h00);

        // R8 select high between bytes: no fault
        @(negedge clk); slave_sel_n = 1'b1;
        @(negedge clk); slave_sel_n = 1'b0;
        pulse_start();
        #1 check("R8 select rose", {7'b0, mode_fault}, 8'h00);
        // R8 phase 1
        wr(2'd0, 8'h20);
        pulse_start();
        #1 check("R8 phase1", {7'b0, mode_fault}, 8'h00);
        // R8 master mode
        wr(2'd0, 8'h08);
        pulse_start();
        #1 check("R8 master", {7'b0, mode_fault}, 8'h00);

        // R9 set wins over clear in the same cycle
        wr(2'd0, 8'h00);
        @(negedge clk);
        bus_addr = 2'd1; bus_wdata = 8'h01; bus_wr = 1'b1; xfer_start = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; xfer_start = 1'b0;
        #1 check("R9 set wins", {7'b0, mode_fault}, 8'h01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule